// File: doc/BRIEF.md
# GPIO Expander Interrupt Controller

This block is the interrupt logic of a two-port, 16-pin input expander. Each pin is brought into the clock domain through a two-flop synchronizer and compared against a reference snapshot. The snapshot is the value that pin had when software last read its port's input register. When an unmasked pin differs from its snapshot, the block pulls its interrupt output low. The output is open-drain, modelled as an active-low level `int_n` together with a drive enable `int_oe`. Reading a port's input register takes a fresh snapshot for that port, and that clears the port's pending conditions.

A per-pin latch option keeps a short excursion from being lost. With latching off, a pin that returns to its snapshot value before the port is read simply stops requesting, and the event is gone. With latching on, the first change is captured and held, and the read returns the captured value until the port is read. Mask and latch-enable registers are written and read through a simple strobe interface with an 8-bit address. The serial bus front end and the pads sit outside the block.

Each pin is a small state machine with two states. `CELL_QUIET` compares the live value against the snapshot. `CELL_HELD` holds a captured change. The transition *capture* (QUIET→HELD) fires when latching is enabled, the live value differs from the snapshot, and no read of that port happens in the same cycle. The transition *release* (HELD→QUIET) fires on a read of the pin's port. The output has its own state machine, also with two states. `IRQ_RELEASED` leaves the line undriven. `IRQ_DRIVING` pulls it low. The transition *assert* (RELEASED→DRIVING) fires when any unmasked pin is pending. The transition *drop* (DRIVING→RELEASED) fires when no unmasked pin is pending.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the following hold: every mask bit is 1, every latch-enable bit is 0, every snapshot is 0, `int_oe`=0, `int_n`=1 and `rdata`=0.
- R2: A pin whose mask bit is 1 never causes `int_oe` to rise, whatever it does.
- R3: An unmasked pin whose synchronized value differs from its snapshot gives `int_oe`=1 and `int_n`=0. This holds from the third rising edge after the pin changes.
- R4: An unlatched pin that returns to its snapshot value before its port is read stops requesting. `int_oe` falls, and the event is not kept.
- R5: A latch-enabled pin that changes is held pending even after the pin returns to its snapshot value. The hold lasts until its port's input register is read.
- R6: A read of address 0x00 clears only the conditions of pins 7..0. A read of 0x01 clears only the conditions of pins 15..8. A condition still pending on the other port keeps `int_oe`=1.
- R7: A port read makes that port's current synchronized pin values its new snapshot. No interrupt follows until a pin differs from that snapshot again.
- R8: A read of 0x00 or 0x01 returns the captured value for a held pin and the live synchronized value for every other pin. The result appears on `rdata` one cycle after the strobe and stays there until the next read.
- R9: Setting a mask bit to 1 while its pin is pending releases `int_oe` within two cycles without clearing the pending condition. Clearing the mask bit to 0 again re-asserts the interrupt.
- R10: The latch enables are at 0x44 (pins 7..0) and 0x45 (pins 15..8). The masks are at 0x4A (pins 7..0) and 0x4B (pins 15..8). All four can be written and read back. Writes to any other address have no effect, and reads of unlisted addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Asynchronous input pins; bits 7..0 are port 0 and bits 15..8 are port 1 |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| int_n | output | 1 | Interrupt level, active low |
| int_oe | output | 1 | Drive enable of the open-drain interrupt: 1 pulls low |

## Verification
The main function is exercised with several kinds of pin stimulus:
- A change on a masked pin, which tells masking apart from snapshot tracking.
- A rise followed by a return, which separates the unlatched loss of an event from the latched hold.
- Overlapping changes on both ports, where reading one port must leave the other port's request standing.
- A mask toggled while a pin is pending, which shows the stored condition survives masking.

Read-back values mixing captured and live bits distinguish a held pin from a live one. A short pulse on a latched high pin confirms that a transient is captured.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam logic [7:0] ADDR_IN_BASE  = 8'h00;
    localparam logic [7:0] ADDR_LAT_BASE = 8'h44;
    localparam logic [7:0] ADDR_MSK_BASE = 8'h4A;

    typedef enum logic {
        CELL_QUIET = 1'b0,
        CELL_HELD  = 1'b1
    } cell_st_e;

    typedef enum logic {
        IRQ_RELEASED = 1'b0,
        IRQ_DRIVING  = 1'b1
    } irq_st_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell import gpio_irq_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic latch_en,
    input  logic clear,
    output logic pend,
    output logic held,
    output logic rd_bit
);
    cell_st_e state_q, state_d;
    logic     ref_q;
    logic     cap_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_QUIET: if (!clear && latch_en && (live != ref_q)) state_d = CELL_HELD;
            CELL_HELD:  if (clear) state_d = CELL_QUIET;
            default:    state_d = CELL_QUIET;
        endcase
    end

    // state register with snapshot and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_QUIET;
            ref_q   <= 1'b0;
            cap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clear) ref_q <= live;
            if (state_q == CELL_QUIET && state_d == CELL_HELD) cap_q <= live;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CELL_QUIET: begin
                pend   = (live != ref_q);
                held   = 1'b0;
                rd_bit = live;
            end
            CELL_HELD: begin
                pend   = 1'b1;
                held   = 1'b1;
                rd_bit = cap_q;
            end
            default: begin
                pend   = 1'b0;
                held   = 1'b0;
                rd_bit = live;
            end
        endcase
    end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out import gpio_irq_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic int_oe,
    output logic int_n
);
    irq_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_RELEASED: if (req)  state_d = IRQ_DRIVING;
            IRQ_DRIVING:  if (!req) state_d = IRQ_RELEASED;
            default:      state_d = IRQ_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RELEASED: begin int_oe = 1'b0; int_n = 1'b1; end
            IRQ_DRIVING:  begin int_oe = 1'b1; int_n = 1'b0; end
            default:      begin int_oe = 1'b0; int_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_irq_pkg::*; #(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PORT_W*NUM_PORTS-1:0] pin_in,
    input  logic                        rd_stb,
    input  logic                        wr_stb,
    input  logic [7:0]                  addr,
    input  logic [PORT_W-1:0]           wdata,
    output logic [PORT_W-1:0]           rdata,
    output logic                        int_n,
    output logic                        int_oe
);
    localparam int PIN_W = PORT_W * NUM_PORTS;

    logic [PIN_W-1:0]     live;
    logic [PIN_W-1:0]     pend_vec;
    logic [PIN_W-1:0]     held_vec;
    logic [PIN_W-1:0]     rd_vec;
    logic [PIN_W-1:0]     mask_q;
    logic [PIN_W-1:0]     latch_q;
    logic [NUM_PORTS-1:0] port_rd;
    logic [PORT_W-1:0]    rd_val;
    logic                 any_req;

    gpio_irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (live)
    );

    // per-port read strobes
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign port_rd[p] = rd_stb && (addr == ADDR_IN_BASE + 8'(p));
        end
    endgenerate

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            latch_q <= '0;
        end else if (wr_stb) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr == ADDR_MSK_BASE + 8'(p)) mask_q[p*PORT_W +: PORT_W]  <= wdata;
                if (addr == ADDR_LAT_BASE + 8'(p)) latch_q[p*PORT_W +: PORT_W] <= wdata;
            end
        end
    end

    // one change cell per pin
    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_cell
            gpio_irq_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .live    (live[i]),
                .latch_en(latch_q[i]),
                .clear   (port_rd[i / PORT_W]),
                .pend    (pend_vec[i]),
                .held    (held_vec[i]),
                .rd_bit  (rd_vec[i])
            );
        end
    endgenerate

    // read mux
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_IN_BASE + 8'(p))  rd_val = rd_vec[p*PORT_W +: PORT_W];
            if (addr == ADDR_LAT_BASE + 8'(p)) rd_val = latch_q[p*PORT_W +: PORT_W];
            if (addr == ADDR_MSK_BASE + 8'(p)) rd_val = mask_q[p*PORT_W +: PORT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_val;
    end

    assign any_req = |(pend_vec & ~mask_q);

    gpio_irq_out u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (any_req),
        .int_oe(int_oe),
        .int_n (int_n)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk import gpio_irq_pkg::*; #(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rd_stb,
    input logic [7:0]                  addr,
    input logic [PORT_W*NUM_PORTS-1:0] mask,
    input logic [PORT_W*NUM_PORTS-1:0] held,
    input logic [PORT_W*NUM_PORTS-1:0] pend,
    input logic                        int_oe
);
    // R3
    irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~mask)) |=> int_oe);

    // R2
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & ~mask)) |=> !int_oe);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
            // R6
            own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_stb && addr == ADDR_IN_BASE + 8'(p)) |=> (held[p*PORT_W +: PORT_W] == '0));

            // R5
            hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_stb && addr == ADDR_IN_BASE + 8'(p)) |=>
                ((held[p*PORT_W +: PORT_W] & $past(held[p*PORT_W +: PORT_W]))
                    == $past(held[p*PORT_W +: PORT_W])));

            for (genvar q = 0; q < NUM_PORTS; q++) begin : g_q
                if (q != p) begin : g_other
                    // R6
                    other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                        (rd_stb && addr == ADDR_IN_BASE + 8'(p) && (|held[q*PORT_W +: PORT_W]))
                        |=> (|held[q*PORT_W +: PORT_W]));
                end
            end
        end
    endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_stb(rd_stb),
    .addr  (addr),
    .mask  (mask_q),
    .held  (held_vec),
    .pend  (pend_vec),
    .int_oe(int_oe)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_PIN = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;
    localparam int NVEC = 21;

    // {op, addr, data, exp_oe, chk_rd, exp_rd, req}
    localparam logic [39:0] VEC [NVEC] = '{
        {OP_PIN, 8'h00, 16'h0001, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 masked change
        {OP_RD,  8'h00, 16'h0000, 1'b0, 1'b1, 8'h01, 4'd8},  // R8 live read
        {OP_WR,  8'h4A, 16'h0000, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 snapshot already taken
        {OP_PIN, 8'h00, 16'h0003, 1'b1, 1'b0, 8'h00, 4'd3},  // R3 enabled change
        {OP_PIN, 8'h00, 16'h0001, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 return loses event
        {OP_RD,  8'h4A, 16'h0000, 1'b0, 1'b1, 8'h00, 4'd10}, // R10 mask readback
        {OP_WR,  8'h44, 16'h0004, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 latch write
        {OP_RD,  8'h44, 16'h0000, 1'b0, 1'b1, 8'h04, 4'd10}, // R10 latch readback
        {OP_PIN, 8'h00, 16'h0005, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 latched change
        {OP_PIN, 8'h00, 16'h0001, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 held after return
        {OP_RD,  8'h00, 16'h0000, 1'b0, 1'b1, 8'h05, 4'd8},  // R8 captured plus live
        {OP_WR,  8'h4B, 16'h0000, 1'b0, 1'b0, 8'h00, 4'd9},  // R9 unmask port 1
        {OP_PIN, 8'h00, 16'h0101, 1'b1, 1'b0, 8'h00, 4'd3},  // R3 port 1 change
        {OP_RD,  8'h00, 16'h0000, 1'b1, 1'b1, 8'h01, 4'd6},  // R6 other port kept
        {OP_RD,  8'h01, 16'h0000, 1'b0, 1'b1, 8'h01, 4'd6},  // R6 own port cleared
        {OP_PIN, 8'h00, 16'h0301, 1'b1, 1'b0, 8'h00, 4'd3},  // R3
        {OP_WR,  8'h4B, 16'h0002, 1'b0, 1'b0, 8'h00, 4'd9},  // R9 mask pending bit
        {OP_WR,  8'h4B, 16'h0000, 1'b1, 1'b0, 8'h00, 4'd9},  // R9 status kept
        {OP_RD,  8'h01, 16'h0000, 1'b0, 1'b1, 8'h03, 4'd7},  // R7 new snapshot
        {OP_WR,  8'h00, 16'h00FF, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 write ignored
        {OP_RD,  8'h4A, 16'h0000, 1'b0, 1'b1, 8'h00, 4'd10}  // R10 mask unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        int_n;
    logic        int_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    gpio_irq_ctrl dut (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .rd_stb(rd_stb),
        .wr_stb(wr_stb),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .int_n (int_n),
        .int_oe(int_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        case (op)
            OP_PIN: pin_in = d;
            OP_WR:  begin addr = a; wdata = d[7:0]; wr_stb = 1'b1; end
            default: begin addr = a; rd_stb = 1'b1; end
        endcase
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, {15'd0, int_oe}, 16'd0, "int_oe at reset");
        check(1, {15'd0, int_n}, 16'd1, "int_n at reset");
        check(1, {8'd0, rdata}, 16'd0, "rdata at reset");
        rst_n = 1'b1;
        do_op(OP_RD, 8'h4B, 16'h0);
        check(1, {8'd0, rdata}, 16'h00FF, "mask reset");
        do_op(OP_RD, 8'h45, 16'h0);
        check(1, {8'd0, rdata}, 16'h0000, "latch reset");

        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] v;
            v = VEC[i];
            do_op(v[39:38], v[37:30], v[29:14]);
            check(int'(v[3:0]), {15'd0, int_oe}, {15'd0, v[13]}, "int_oe");
            if (v[12]) check(int'(v[3:0]), {8'd0, rdata}, {8'd0, v[11:4]}, "rdata");
        end

        // R5 short pulse on a latched pin of port 1 is captured
        do_op(OP_WR, 8'h45, 16'h0080);
        @(negedge clk);
        pin_in = 16'h8301;
        repeat (3) @(negedge clk);
        pin_in = 16'h0301;
        repeat (5) @(negedge clk);
        check(5, {15'd0, int_oe}, 16'd1, "pulse held int_oe");
        // R3 level output follows drive
        check(3, {15'd0, int_n}, 16'd0, "int_n while driving");
        // R8 captured bit mixed with live bits
        do_op(OP_RD, 8'h01, 16'h0);
        check(8, {8'd0, rdata}, 16'h0083, "pulse read value");
        check(6, {15'd0, int_oe}, 16'd0, "released after read");
        check(4, {15'd0, int_n}, 16'd1, "int_n released");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule